// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Entry and Return

This block is the program-control engine of a small processor core. Each accepted command retires one instruction's worth of control flow. It can step the program counter, take a relative branch selected by the condition flags, call a subroutine, or return from one. A downward-growing stack in an external synchronous memory holds return addresses. The block also keeps a five-bit status word: carry, zero, negative and overflow flags plus an interrupt enable bit. An ALU beside the block writes the flags through a dedicated port.

An interrupt is considered only at an instruction boundary, which is the idle state with no operation in flight. When the enable bit is set and the request line is high, the block behaves like a forced call. It pushes the program counter and then the status word, jumps to a fixed vector and clears the enable bit. An interrupt return pops the status word and then the program counter, so the enable bit comes back as it was before entry.

Commands arrive over a valid/ready pair. The source presents a command with `cmd_valid` and must hold all command fields steady until a cycle in which `cmd_ready` is also high. That cycle is the acceptance cycle. `cmd_ready` is low while a multi-cycle operation is in progress, and also in the cycle an interrupt is being taken. The flag port, the enable port and the interrupt request are plain level signals.

Top module: `prog_ctrl_unit`

## Requirements
- R1: After reset the program counter is 0, the stack pointer equals STACK_TOP (default 0xF0), all status bits are 0 and busy is low.
- R2: An accepted step command (code 0) sets the program counter to its old value plus one at the next clock edge.
- R3: An accepted branch command (code 1) evaluates cmd_cond against the status flags. The encodings are 0 always, 1 Z, 2 not Z, 3 C, 4 not C, 5 N, 6 V, 7 N xor V. Status bits are bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 interrupt enable. When taken, the program counter becomes pc + cmd_off (two's complement, modulo 2^PC_W). Otherwise it becomes pc + 1. Codes 5 to 7 of cmd_op act as a step.
- R4: An accepted call command (code 2) does three things in the same cycle: it writes pc + 1 to address sp - 1, decrements sp, and loads pc + cmd_off into the program counter.
- R5: An accepted return command (code 3) reads the word at sp and increments sp. The word read is loaded into the program counter one cycle later, and busy is high during that cycle.
- R6: A command takes effect only in a cycle where cmd_valid and cmd_ready are both high. cmd_ready is low whenever busy is high.
- R7: When the block is idle, irq is high and the enable bit is set, it takes an interrupt instead of a command, with cmd_ready low. It writes the program counter to sp - 1. In the next cycle, with busy high, it writes the status word (zero-extended) to the new sp - 1, sets the program counter to VECTOR (default 0x0100) and clears the enable bit.
- R8: While the enable bit is clear, irq has no effect and commands are accepted as usual.
- R9: An accepted interrupt return (code 4) pops the status word in the first following cycle and the program counter in the second. Busy is high in both cycles, and sp rises by two in total.
- R10: flag_we loads flag_in (same bit order as the status word) into the four condition flags in any cycle except the status-restore cycle of R9. A branch in the same cycle uses the old flags. ie_we loads ie_in into the enable bit only when the block is idle and not taking an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 3 | Command code: 0 step, 1 branch, 2 call, 3 return, 4 interrupt return |
| cmd_off | input | PC_W | Signed relative offset for branch and call |
| cmd_cond | input | 3 | Branch condition select |
| flag_we | input | 1 | Write the condition flags |
| flag_in | input | 4 | New flags {V,N,Z,C} |
| ie_we | input | 1 | Write the interrupt enable bit |
| ie_in | input | 1 | New interrupt enable value |
| irq | input | 1 | Interrupt request, level |
| busy | output | 1 | Multi-cycle operation in progress |
| pc | output | PC_W | Program counter |
| sp | output | SP_W | Stack pointer |
| psr | output | 5 | Status word {IE,V,N,Z,C} |
| mem_en | output | 1 | Stack memory access strobe |
| mem_we | output | 1 | Stack memory write when high, read when low |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | PC_W | Stack memory write data |
| mem_rdata | input | PC_W | Stack memory read data, valid the cycle after a read |

## Verification
Step, branch and call results are visible on pc and sp one clock after acceptance. A return shows the new sp one clock after acceptance and the popped pc one clock after that. An interrupt return restores psr after two clocks and pc after three. Interrupt entry shows the vector and the cleared enable bit two clocks after the idle cycle in which irq was seen. The bench keeps a behavioural model that advances on the same rising edge as the design. It compares pc, sp, psr, busy and cmd_ready a few nanoseconds after every falling edge, so each result is checked exactly in the cycle it is due and never one cycle early or late.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PSR_W  = 5;
  localparam int PSR_C  = 0;
  localparam int PSR_Z  = 1;
  localparam int PSR_N  = 2;
  localparam int PSR_V  = 3;
  localparam int PSR_IE = 4;

  typedef enum logic [2:0] {
    OP_STEP   = 3'd0,
    OP_BRANCH = 3'd1,
    OP_CALL   = 3'd2,
    OP_RET    = 3'd3,
    OP_IRET   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_IRQ_PSR = 2'd1,
    ST_POP_PSR = 2'd2,
    ST_POP_PC  = 2'd3
  } state_e;
endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval (
  input  logic [3:0] flags,
  input  logic [2:0] sel,
  output logic       hit
);
  import pcu_pkg::*;

  always_comb begin
    case (sel)
      3'd0:    hit = 1'b1;
      3'd1:    hit = flags[PSR_Z];
      3'd2:    hit = !flags[PSR_Z];
      3'd3:    hit = flags[PSR_C];
      3'd4:    hit = !flags[PSR_C];
      3'd5:    hit = flags[PSR_N];
      3'd6:    hit = flags[PSR_V];
      default: hit = flags[PSR_N] ^ flags[PSR_V];
    endcase
  end
endmodule

// File: rtl/pcu_sp_reg.sv
module pcu_sp_reg #(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] TOP = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dec,
  input  logic            inc,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_m1
);
  assign sp_m1 = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)      sp <= TOP;
    else if (dec) sp <= sp_m1;
    else if (inc) sp <= sp + 1'b1;
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] off,
  output logic [PC_W-1:0] pc_inc,
  output logic [PC_W-1:0] pc_rel
);
  assign pc_inc = pc + 1'b1;
  assign pc_rel = pc + off;
endmodule

// File: rtl/prog_ctrl_unit.sv
module prog_ctrl_unit #(
  parameter int PC_W = 16,
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] STACK_TOP = 8'hF0,
  parameter logic [PC_W-1:0] VECTOR = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [PC_W-1:0] cmd_off,
  input  logic [2:0]      cmd_cond,
  input  logic            flag_we,
  input  logic [3:0]      flag_in,
  input  logic            ie_we,
  input  logic            ie_in,
  input  logic            irq,
  output logic            busy,
  output logic [PC_W-1:0] pc,
  output logic [SP_W-1:0] sp,
  output logic [4:0]      psr,
  output logic            mem_en,
  output logic            mem_we,
  output logic [SP_W-1:0] mem_addr,
  output logic [PC_W-1:0] mem_wdata,
  input  logic [PC_W-1:0] mem_rdata
);
  import pcu_pkg::*;

  state_e          state, state_d;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, pc_rel;
  logic [PSR_W-1:0] psr_q;
  logic [SP_W-1:0] sp_q, sp_m1;
  logic            sp_dec, sp_inc;
  logic            take_irq, accept, cond_hit, restore, clr_ie;

  pcu_cond_eval u_cond (
    .flags (psr_q[3:0]),
    .sel   (cmd_cond),
    .hit   (cond_hit)
  );

  pcu_target #(.PC_W(PC_W)) u_tgt (
    .pc     (pc_q),
    .off    (cmd_off),
    .pc_inc (pc_inc),
    .pc_rel (pc_rel)
  );

  pcu_sp_reg #(.SP_W(SP_W), .TOP(STACK_TOP)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .dec   (sp_dec),
    .inc   (sp_inc),
    .sp    (sp_q),
    .sp_m1 (sp_m1)
  );

  assign take_irq  = (state == ST_IDLE) && irq && psr_q[PSR_IE];
  assign cmd_ready = (state == ST_IDLE) && !take_irq;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_d   = state;
    pc_d      = pc_q;
    sp_dec    = 1'b0;
    sp_inc    = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    restore   = 1'b0;
    clr_ie    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (take_irq) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = sp_m1;
          mem_wdata = pc_q;
          sp_dec    = 1'b1;
          state_d   = ST_IRQ_PSR;
        end else if (accept) begin
          case (cmd_op)
            OP_BRANCH: pc_d = cond_hit ? pc_rel : pc_inc;
            OP_CALL: begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = sp_m1;
              mem_wdata = pc_inc;
              sp_dec    = 1'b1;
              pc_d      = pc_rel;
            end
            OP_RET: begin
              mem_en  = 1'b1;
              sp_inc  = 1'b1;
              state_d = ST_POP_PC;
            end
            OP_IRET: begin
              mem_en  = 1'b1;
              sp_inc  = 1'b1;
              state_d = ST_POP_PSR;
            end
            default: pc_d = pc_inc;
          endcase
        end
      end
      ST_IRQ_PSR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_m1;
        mem_wdata = PC_W'(psr_q);
        sp_dec    = 1'b1;
        pc_d      = VECTOR;
        clr_ie    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_POP_PSR: begin
        restore = 1'b1;
        mem_en  = 1'b1;
        sp_inc  = 1'b1;
        state_d = ST_POP_PC;
      end
      default: begin
        pc_d    = mem_rdata;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc_q  <= '0;
    end else begin
      state <= state_d;
      pc_q  <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q <= '0;
    end else if (restore) begin
      psr_q <= mem_rdata[PSR_W-1:0];
    end else begin
      if (flag_we) psr_q[3:0] <= flag_in;
      if (clr_ie) psr_q[PSR_IE] <= 1'b0;
      else if (ie_we && state == ST_IDLE && !take_irq) psr_q[PSR_IE] <= ie_in;
    end
  end

  assign busy = (state != ST_IDLE);
  assign pc   = pc_q;
  assign sp   = sp_q;
  assign psr  = psr_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            irq,
  input logic            busy,
  input logic [PC_W-1:0] pc,
  input logic [SP_W-1:0] sp,
  input logic [4:0]      psr,
  input logic            mem_en,
  input logic            mem_we
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd0) |=> pc == PC_W'($past(pc) + 1'b1));

  p_call_sp_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd2) |=> sp == SP_W'($past(sp) - 1'b1));

  p_ret_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd3) |=> (busy && sp == SP_W'($past(sp) + 1'b1)));

  p_ready_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cmd_ready);

  p_irq_take_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && irq && psr[4]) |-> (!cmd_ready && mem_en && mem_we));

  p_irq_next_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && irq && psr[4]) |=> (busy && mem_we));

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !psr[4] && cmd_valid) |-> cmd_ready);

  p_iret_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 3'd4) |=> (busy && !mem_we));
endmodule

bind prog_ctrl_unit pcu_checker #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .irq       (irq),
  .busy      (busy),
  .pc        (pc),
  .sp        (sp),
  .psr       (psr),
  .mem_en    (mem_en),
  .mem_we    (mem_we)
);

// File: tb/test_prog_ctrl_unit.sv
module test_prog_ctrl_unit;
  localparam int PC_W = 16;
  localparam int SP_W = 8;
  localparam logic [7:0]  TOP = 8'hF0;
  localparam logic [15:0] VEC = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0, cmd_cond = '0;
  logic [15:0] cmd_off = '0;
  logic flag_we = 1'b0, ie_we = 1'b0, ie_in = 1'b0, irq = 1'b0;
  logic [3:0] flag_in = '0;
  logic busy, mem_en, mem_we;
  logic [15:0] pc, mem_wdata;
  logic [7:0] sp, mem_addr;
  logic [4:0] psr;
  logic [15:0] mem_rdata;

  always #10 clk = ~clk;

  prog_ctrl_unit #(.PC_W(PC_W), .SP_W(SP_W), .STACK_TOP(TOP), .VECTOR(VEC)) i_prog_ctrl_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_off(cmd_off), .cmd_cond(cmd_cond),
    .flag_we(flag_we), .flag_in(flag_in), .ie_we(ie_we), .ie_in(ie_in),
    .irq(irq), .busy(busy), .pc(pc), .sp(sp), .psr(psr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // stack memory seen by the design
  logic [15:0] tb_mem [256];
  always @(posedge clk) begin
    if (mem_en && mem_we) tb_mem[mem_addr] <= mem_wdata;
    else if (mem_en)      mem_rdata <= tb_mem[mem_addr];
  end

  // behavioural reference
  logic [15:0] m_mem [256];
  logic [15:0] m_pc, m_rd;
  logic [7:0]  m_sp, m_t;
  logic [4:0]  m_psr, m_old;
  int          m_ph;

  function automatic bit cond_ok(input logic [2:0] s, input logic [3:0] f);
    // f: [0]C [1]Z [2]N [3]V
    case (s)
      3'd0: return 1'b1;
      3'd1: return f[1];
      3'd2: return !f[1];
      3'd3: return f[0];
      3'd4: return !f[0];
      3'd5: return f[2];
      3'd6: return f[3];
      default: return f[2] != f[3];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pc = '0; m_sp = TOP; m_psr = '0; m_ph = 0;
    end else begin
      m_old = m_psr;
      case (m_ph)
        0: begin
          if (irq && m_old[4]) begin
            m_t = m_sp - 8'd1; m_mem[m_t] = m_pc; m_sp = m_t; m_ph = 1;
          end else begin
            if (ie_we) m_psr[4] = ie_in;
            if (cmd_valid) begin
              case (cmd_op)
                3'd1: m_pc = cond_ok(cmd_cond, m_old[3:0]) ? m_pc + cmd_off : m_pc + 16'd1;
                3'd2: begin
                  m_t = m_sp - 8'd1; m_mem[m_t] = m_pc + 16'd1; m_sp = m_t;
                  m_pc = m_pc + cmd_off;
                end
                3'd3: begin m_rd = m_mem[m_sp]; m_sp = m_sp + 8'd1; m_ph = 3; end
                3'd4: begin m_rd = m_mem[m_sp]; m_sp = m_sp + 8'd1; m_ph = 2; end
                default: m_pc = m_pc + 16'd1;
              endcase
            end
          end
          if (flag_we) m_psr[3:0] = flag_in;
        end
        1: begin
          m_t = m_sp - 8'd1; m_mem[m_t] = {11'd0, m_old}; m_sp = m_t;
          m_pc = VEC; m_psr[4] = 1'b0;
          if (flag_we) m_psr[3:0] = flag_in;
          m_ph = 0;
        end
        2: begin
          m_psr = m_rd[4:0]; m_rd = m_mem[m_sp]; m_sp = m_sp + 8'd1; m_ph = 3;
        end
        default: begin
          m_pc = m_rd;
          if (flag_we) m_psr[3:0] = flag_in;
          m_ph = 0;
        end
      endcase
    end
  end

  int    n_chk = 0, n_fail = 0, n_cyc = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  task automatic compare();
    logic [30:0] act, exp;
    act = {pc, sp, psr, busy, cmd_ready};
    exp = {m_pc, m_sp, m_psr, m_ph != 0, (m_ph == 0) && !(irq && m_psr[4])};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s {pc,sp,psr,busy,rdy} actual=%h expected=%h at %0t", cur_tag, act, exp, $time);
    end
  endtask

  task automatic cyc(output bit acc);
    #2;
    compare();
    acc = cmd_valid && cmd_ready;
    @(posedge clk);
    @(negedge clk);
    flag_we = 1'b0;
    ie_we = 1'b0;
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) cyc(a);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] off, input logic [2:0] cs);
    bit a;
    cmd_valid = 1'b1; cmd_op = op; cmd_off = off; cmd_cond = cs;
    a = 1'b0;
    while (!a) cyc(a);
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog actual=%0d cycles expected=<100000", n_cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin tb_mem[i] = '0; m_mem[i] = '0; end
    mem_rdata = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    cur_tag = "R1";
    #2;
    n_chk++;
    if ({pc, sp, psr, busy} !== {16'h0, TOP, 5'h0, 1'b0}) begin
      n_fail++;
      $display("FAIL R1 reset actual=%h expected=%h", {pc, sp, psr, busy}, {16'h0, TOP, 5'h0, 1'b0});
    end
    @(negedge clk);
    idle(2);

    cur_tag = "R2";
    for (int i = 0; i < 3; i++) issue(3'd0, 16'h0, 3'd0);

    // R10: branch sees flags from before the same-cycle write
    cur_tag = "R10";
    flag_we = 1'b1; flag_in = 4'b0010;
    issue(3'd1, 16'h0040, 3'd1);
    issue(3'd1, 16'h0040, 3'd1);

    // R3: every condition against several flag patterns
    cur_tag = "R3";
    foreach (flag_in[k]) begin end
    for (int p = 0; p < 6; p++) begin
      flag_we = 1'b1;
      case (p)
        0: flag_in = 4'b0000;
        1: flag_in = 4'b1111;
        2: flag_in = 4'b0101;
        3: flag_in = 4'b1000;
        4: flag_in = 4'b0100;
        default: flag_in = 4'b1100;
      endcase
      idle(1);
      for (int c = 0; c < 8; c++) issue(3'd1, (c % 2) ? 16'hFFFD : 16'h0005, 3'(c));
    end
    issue(3'd6, 16'h0, 3'd0);

    // R4 / R5: nested call and return
    cur_tag = "R4";
    issue(3'd2, 16'h0020, 3'd0);
    issue(3'd0, 16'h0, 3'd0);
    issue(3'd2, 16'hFF00, 3'd0);
    cur_tag = "R5";
    issue(3'd3, 16'h0, 3'd0);
    issue(3'd3, 16'h0, 3'd0);
    cur_tag = "R6";
    issue(3'd2, 16'h0011, 3'd0);
    issue(3'd3, 16'h0, 3'd0);
    issue(3'd0, 16'h0, 3'd0);

    // R8: request ignored while disabled
    cur_tag = "R8";
    irq = 1'b1;
    for (int i = 0; i < 4; i++) issue(3'd0, 16'h0, 3'd0);

    // R7: enabling with request pending, entry, masked inside the handler
    cur_tag = "R7";
    flag_we = 1'b1; flag_in = 4'b1010;
    ie_we = 1'b1; ie_in = 1'b1;
    idle(1);
    ie_we = 1'b1; ie_in = 1'b0;
    idle(3);
    issue(3'd0, 16'h0, 3'd0);
    issue(3'd0, 16'h0, 3'd0);
    irq = 1'b0;
    flag_we = 1'b1; flag_in = 4'b0001;
    idle(1);

    // R9 / R10: return restores enable and flags; flag write in restore cycle ignored
    cur_tag = "R9";
    issue(3'd4, 16'h0, 3'd0);
    cur_tag = "R10";
    flag_we = 1'b1; flag_in = 4'b0110;
    ie_we = 1'b1; ie_in = 1'b0;
    idle(1);
    cur_tag = "R9";
    idle(2);

    // R7: request arriving with a command waiting
    cur_tag = "R7";
    cmd_valid = 1'b1; cmd_op = 3'd0; irq = 1'b1;
    idle(3);
    cmd_valid = 1'b0; irq = 1'b0;
    cur_tag = "R9";
    issue(3'd4, 16'h0, 3'd0);
    idle(3);

    // mixed traffic
    cur_tag = "R6";
    for (int i = 0; i < 300; i++) begin
      irq = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) begin flag_we = 1'b1; flag_in = 4'($urandom); end
      if (($urandom % 5) == 0) begin ie_we = 1'b1; ie_in = 1'($urandom); end
      if (($urandom % 4) == 0) idle(1);
      else issue(3'($urandom % 7), 16'($urandom), 3'($urandom));
    end
    irq = 1'b0;
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule